// File: doc/BRIEF.md
# Partitioned Memory Map Decoder

This block steers every memory access of an 8-bit microcontroller core either to one shared nonvolatile RAM on a byte-wide bus or to the external expanded bus. Program space and data space are separate 64K-byte maps. Both live in the same physical RAM. A partition boundary decides where the RAM stops holding program and starts holding data. Data addresses are shifted up by the boundary, so data address 0 lands just above the program segment. A range setting gives how much RAM is installed. Anything that falls outside it goes to the expanded bus.

A single control register holds both settings and is written over the special-function-register port. The partition can be changed at any time. The range is taken only once after reset and is then frozen. The outputs are registered. They give one chip enable per 8K-byte RAM block, a write strobe for the byte-wide bus, the translated RAM address and a select for the expanded bus. All of them are valid in the cycle after the access is presented.

Top module: `mmap_decoder`

## Requirements
- R1: After reset the partition field is 31 (boundary 32K), the range field is 0 (8K installed), and bw_ce, bw_wr, exp_sel and bw_addr are all zero.
- R2: A fetch (acc_fetch=1) whose address is below both the boundary and the installed range goes to RAM at the same address. bw_ce bit `addr[15:13]` rises one cycle after the access.
- R3: A fetch at or above the boundary, or at or above the installed range, asserts exp_sel and no chip enable. bw_addr reads 0 in that case.
- R4: A data access (acc_fetch=0) is translated to addr + boundary. If the result is below the installed range it goes to RAM at that address with the matching block enable. Otherwise, including any result of 64K or more, it goes to the expanded bus.
- R5: bw_wr is 1 only for a data write (acc_wr=1) that maps to RAM. A fetch with acc_wr=1 never asserts it.
- R6: At most one bit of bw_ce is set, and bw_ce is never set together with exp_sel.
- R7: A write with sfr_we=1 to SFR address C6h loads the partition field from sfr_wdata[4:0], and the following access already uses the new boundary. A write to any other SFR address changes nothing.
- R8: The range field, sfr_wdata[7:5], is loaded only by the first C6h write after reset. In later writes it is ignored.
- R9: The boundary is (p+1)×1K for partition field p, so it is at most 32K. The installed range is (r+1)×8K for range field r.
- R10: A cycle with acc_valid=0 leaves bw_ce, bw_wr and exp_sel at 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_fetch | input | 1 | 1 = instruction fetch, 0 = data move |
| acc_wr | input | 1 | Write indication from the core |
| acc_addr | input | 16 | Core address in the selected space |
| sfr_we | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| bw_ce | output | 8 | Chip enable, one per 8K RAM block |
| bw_wr | output | 1 | Byte-wide bus write strobe |
| bw_addr | output | 16 | Translated RAM address |
| exp_sel | output | 1 | Access routed to the expanded bus |

## Verification
The hardest case to reach is the frozen range after a later control write. From the ports it looks the same as a correct range until a data access lands in the gap between the old and the requested size. The bench locks a 32K range and then writes 64K together with a new partition. It then sends a data access whose translated address is exactly 8000h. That access must go to the expanded bus, while a neighbour one byte lower still hits RAM. The 64K overflow of the data translation is reached with a data write at FFFFh.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
    localparam int ADDR_W   = 16;
    localparam int BLK_W    = 13;
    localparam int GRAN_W   = 10;
    localparam int PFLD_W   = 5;
    localparam int RFLD_W   = 3;
    localparam int SFR_W    = 8;
    localparam int NUM_BLK  = 2 ** (ADDR_W - BLK_W);
    localparam int BIDX_W   = ADDR_W - BLK_W;
    localparam int XW       = ADDR_W + 1;
    localparam logic [SFR_W-1:0] MCTL_SFR = 8'hC6;

    typedef struct packed {
        logic [PFLD_W-1:0] part;
        logic [RFLD_W-1:0] range;
        logic              locked;
    } mctl_t;

    typedef struct packed {
        logic [NUM_BLK-1:0] ce;
        logic               wr;
        logic               exp;
        logic [ADDR_W-1:0]  raddr;
    } dec_t;
endpackage

// File: rtl/mctl_reg.sv
module mctl_reg
    import mmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sfr_we,
    input  logic [SFR_W-1:0]  sfr_addr,
    input  logic [SFR_W-1:0]  sfr_wdata,
    output logic [PFLD_W-1:0] part,
    output logic [RFLD_W-1:0] range
);
    mctl_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (sfr_we && sfr_addr == MCTL_SFR) begin
            cfg_d.part = sfr_wdata[PFLD_W-1:0];
            if (!cfg_q.locked) begin
                cfg_d.range  = sfr_wdata[PFLD_W +: RFLD_W];
                cfg_d.locked = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.part   <= '1;
            cfg_q.range  <= '0;
            cfg_q.locked <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign part  = cfg_q.part;
    assign range = cfg_q.range;

    // R8: once locked the range field never moves
    p_range_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.locked |=> $stable(cfg_q.range));

    // R7: writes to other SFR addresses leave the partition alone
    p_sfr_other_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_we && sfr_addr != MCTL_SFR) |=> $stable(cfg_q.part));
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
    import mmap_pkg::*;
(
    input  logic              fetch,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PFLD_W-1:0] part,
    input  logic [RFLD_W-1:0] range,
    output logic              hit,
    output logic [ADDR_W-1:0] raddr
);
    logic [XW-1:0] bnd, lim, ext, tdat;

    always_comb begin
        bnd  = (XW'(part) + XW'(1)) << GRAN_W;
        lim  = (XW'(range) + XW'(1)) << BLK_W;
        ext  = XW'(addr);
        tdat = ext + bnd;
        if (fetch) begin
            hit   = (ext < bnd) && (ext < lim);
            raddr = hit ? addr : '0;
        end else begin
            hit   = tdat < lim;
            raddr = hit ? tdat[ADDR_W-1:0] : '0;
        end
    end
endmodule

// File: rtl/ce_decode.sv
module ce_decode
    import mmap_pkg::*;
(
    input  logic              hit,
    input  logic [BIDX_W-1:0] blk,
    output logic [NUM_BLK-1:0] ce
);
    for (genvar i = 0; i < NUM_BLK; i++) begin : g_ce
        assign ce[i] = hit && (blk == BIDX_W'(i));
    end
endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
    import mmap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic               acc_fetch,
    input  logic               acc_wr,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic               sfr_we,
    input  logic [SFR_W-1:0]   sfr_addr,
    input  logic [SFR_W-1:0]   sfr_wdata,
    output logic [NUM_BLK-1:0] bw_ce,
    output logic               bw_wr,
    output logic [ADDR_W-1:0]  bw_addr,
    output logic               exp_sel
);
    logic [PFLD_W-1:0]  part;
    logic [RFLD_W-1:0]  range;
    logic               hit;
    logic [ADDR_W-1:0]  raddr;
    logic [NUM_BLK-1:0] ce;
    dec_t out_d, out_q;

    mctl_reg u_mctl (
        .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .part(part), .range(range)
    );

    addr_xlate u_xlate (
        .fetch(acc_fetch), .addr(acc_addr), .part(part), .range(range),
        .hit(hit), .raddr(raddr)
    );

    ce_decode u_ce (
        .hit(hit), .blk(raddr[ADDR_W-1:BLK_W]), .ce(ce)
    );

    always_comb begin
        out_d = '0;
        if (acc_valid) begin
            out_d.ce    = ce;
            out_d.raddr = raddr;
            out_d.exp   = !hit;
            out_d.wr    = hit && !acc_fetch && acc_wr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign bw_ce   = out_q.ce;
    assign bw_wr   = out_q.wr;
    assign bw_addr = out_q.raddr;
    assign exp_sel = out_q.exp;

    p_ce_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bw_ce));
    p_ce_exp_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !((|bw_ce) && exp_sel));
    p_no_fetch_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_fetch) |=> !bw_wr);
    p_wr_in_ram_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bw_wr |-> (|bw_ce));
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (bw_ce == '0 && !bw_wr && !exp_sel));
endmodule

// File: tb/mmap_decoder_bench.sv
module mmap_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_fetch = 1'b0, acc_wr = 1'b0;
    logic [15:0] acc_addr = '0;
    logic        sfr_we = 1'b0;
    logic [7:0]  sfr_addr = '0, sfr_wdata = '0;
    logic [7:0]  bw_ce;
    logic        bw_wr, exp_sel;
    logic [15:0] bw_addr;
    int total = 0, bad = 0, cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mmap_decoder u_mmap_decoder (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_fetch(acc_fetch),
        .acc_wr(acc_wr), .acc_addr(acc_addr), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .bw_ce(bw_ce), .bw_wr(bw_wr), .bw_addr(bw_addr),
        .exp_sel(exp_sel)
    );

    // {fetch, wr, addr, exp raddr, exp ce, exp wr, exp exp_sel}; boundary 8K, range 32K
    localparam logic [43:0] TBL [10] = '{
        {1'b1, 1'b0, 16'h0000, 16'h0000, 8'h01, 1'b0, 1'b0},
        {1'b1, 1'b0, 16'h1FFF, 16'h1FFF, 8'h01, 1'b0, 1'b0},
        {1'b1, 1'b0, 16'h2000, 16'h0000, 8'h00, 1'b0, 1'b1},
        {1'b1, 1'b1, 16'h0100, 16'h0100, 8'h01, 1'b0, 1'b0},
        {1'b0, 1'b0, 16'h0000, 16'h2000, 8'h02, 1'b0, 1'b0},
        {1'b0, 1'b1, 16'h0010, 16'h2010, 8'h02, 1'b1, 1'b0},
        {1'b0, 1'b1, 16'h5FFF, 16'h7FFF, 8'h08, 1'b1, 1'b0},
        {1'b0, 1'b0, 16'h6000, 16'h0000, 8'h00, 1'b0, 1'b1},
        {1'b0, 1'b1, 16'hFFFF, 16'h0000, 8'h00, 1'b0, 1'b1},
        {1'b0, 1'b0, 16'h3ABC, 16'h5ABC, 8'h04, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [7:0] ce, input logic wr,
                       input logic ex, input logic [15:0] ra);
        total++;
        if (bw_ce !== ce || bw_wr !== wr || exp_sel !== ex || bw_addr !== ra) begin
            bad++;
            $display("FAIL %s: got ce=%h wr=%b exp=%b addr=%h, want ce=%h wr=%b exp=%b addr=%h",
                     tag, bw_ce, bw_wr, exp_sel, bw_addr, ce, wr, ex, ra);
        end
    endtask

    task automatic access(input logic f, input logic w, input logic [15:0] a);
        @(negedge clk);
        acc_valid = 1'b1; acc_fetch = f; acc_wr = w; acc_addr = a;
        @(negedge clk);
        acc_valid = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic sfr(input logic [7:0] ad, input logic [7:0] d);
        @(negedge clk);
        sfr_we = 1'b1; sfr_addr = ad; sfr_wdata = d;
        @(negedge clk);
        sfr_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            total++; bad++;
            $display("FAIL watchdog: got cycle=%0d, want below 5000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs", 8'h00, 1'b0, 1'b0, 16'h0000);

        // reset config: boundary 32K, range 8K
        access(1'b1, 1'b0, 16'h1FFF);
        chk("R1/R2 fetch inside 8K", 8'h01, 1'b0, 1'b0, 16'h1FFF);
        access(1'b1, 1'b0, 16'h2000);
        chk("R1/R3 fetch past range", 8'h00, 1'b0, 1'b1, 16'h0000);
        access(1'b0, 1'b1, 16'h0000);
        chk("R1/R4 data above 32K boundary", 8'h00, 1'b0, 1'b1, 16'h0000);

        @(negedge clk);
        acc_fetch = 1'b0; acc_wr = 1'b1; acc_addr = 16'h0000;
        @(negedge clk);
        chk("R10 idle with write held", 8'h00, 1'b0, 1'b0, 16'h0000);
        acc_wr = 1'b0;

        sfr(8'hC7, 8'hE0);
        access(1'b1, 1'b0, 16'h1FFF);
        chk("R7 other SFR address ignored", 8'h01, 1'b0, 1'b0, 16'h1FFF);

        sfr(8'hC6, {3'd3, 5'd7});
        for (int i = 0; i < 10; i++) begin
            access(TBL[i][43], TBL[i][42], TBL[i][41:26]);
            chk($sformatf("R2/R3/R4/R5 table %0d", i), TBL[i][9:2], TBL[i][1],
                TBL[i][0], TBL[i][25:10]);
        end

        // R8: range 64K requested, must stay 32K; partition becomes 2K
        sfr(8'hC6, {3'd7, 5'd1});
        access(1'b1, 1'b0, 16'h0800);
        chk("R7 new boundary used next access", 8'h00, 1'b0, 1'b1, 16'h0000);
        access(1'b1, 1'b0, 16'h07FF);
        chk("R7/R9 fetch below 2K", 8'h01, 1'b0, 1'b0, 16'h07FF);
        access(1'b0, 1'b0, 16'h7800);
        chk("R8 range frozen at 32K", 8'h00, 1'b0, 1'b1, 16'h0000);
        access(1'b0, 1'b0, 16'h77FF);
        chk("R8 last byte of 32K", 8'h08, 1'b0, 1'b0, 16'h7FFF);

        sfr(8'hC6, {3'd0, 5'd31});
        access(1'b1, 1'b0, 16'h7FFF);
        chk("R9 max boundary 32K inside", 8'h08, 1'b0, 1'b0, 16'h7FFF);
        access(1'b1, 1'b1, 16'h8000);
        chk("R9/R5 max boundary edge", 8'h00, 1'b0, 1'b1, 16'h0000);
        access(1'b0, 1'b1, 16'h0000);
        chk("R4/R6 data at 32K offset", 8'h00, 1'b0, 1'b1, 16'h0000);

        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        access(1'b0, 1'b0, 16'h0000);
        chk("R1 config restored by reset", 8'h00, 1'b0, 1'b1, 16'h0000);
        finish_run();
    end
endmodule